// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers 32 peripheral event lines into a single interrupt request for a host processor. A high level on any source line, even for one cycle, is held as a pending event. A per-source enable mask decides which pending events may compete. A configurable ranking picks the most urgent of them. The request output is raised only when global enable is set and that winner outranks every source the host is already servicing.

The host reads the winner in two steps. It first writes the acknowledge bit of the vector register. That write captures the winner's number and moves it from pending to in-service. A later read returns the captured number. If nothing eligible remains when the acknowledge arrives, for example because the source was masked after it fired, the captured number is 0, the error vector, and no state changes. When a handler finishes, the host writes a one to that source's in-service bit. Four serial-channel sources, starting at parameter `SER_BASE` (27 by default), can be reordered among themselves, and any single source can be raised to the top rank.

Top module: `vic_top`

## Requirements
- R1: After reset the config, mask, in-service and vector registers read 0 and `irq_req` is low.
- R2: A high level on `src_in[n]` (n from 1 to 31) at a clock edge makes source n pending. It stays pending until an acknowledge selects it. `src_in[0]` is ignored because vector 0 is the error vector.
- R3: Mask register (address 1): bit n = 1 enables source n. A masked pending source neither requests nor gets selected. It stays pending and competes again once unmasked.
- R4: `irq_req` is high exactly when config bit 16 (global enable) is 1 and an unmasked pending source exists whose rank is strictly better than that of every in-service source.
- R5: Ranking: the source named by config bits 12:8 ranks first. All other sources follow in ascending vector number, except the serial region described in R6.
- R6: Serial channel c is source SER_BASE+c. Slot field s sits at config bits [2s+1:2s] and holds a channel number. Slot s takes the rank of vector SER_BASE+s. A channel named by several slots takes the lowest such slot. A channel named by no slot ranks below every other source.
- R7: A write to address 3 with bit 0 = 1 captures the best unmasked pending source. It clears that source's pending bit and sets its in-service bit. A write to address 3 with bit 0 = 0 changes nothing.
- R8: An acknowledge with no unmasked pending source captures vector 0 and leaves the pending and in-service bits unchanged.
- R9: Reading address 3 returns the captured vector in bits 15:11. Every other bit reads 0.
- R10: Writing address 2 clears each in-service bit whose data bit is 1. Data bits that are 0 have no effect. Reading address 2 returns the in-service bits.
- R11: Address 0 reads back config bits 16:0 as written, with the upper bits 0. `irq_level` always equals config bits 15:13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from registers |
| src_in | input | 32 | Peripheral event lines |
| irq_req | output | 1 | Interrupt request to the host |
| irq_level | output | 3 | Request level field from config |

## Verification
The assertions assume one register access per cycle. They also assume the host clears only in-service bits it means to clear, so no assumption is made about nesting order. The search assertions further assume that the four serial slot fields may hold any value, duplicates included. The stimulus drives at most one write per cycle and keeps source pulses sparse, so that several sources are pending at once and ranks can be compared. The configuration writes mix permutations, duplicated slot fields and global enable both on and off.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int VIC_NSRC  = 32;
    localparam int VIC_VEC_W = $clog2(VIC_NSRC);
    localparam int VIC_KEY_W = VIC_VEC_W + 2;
    localparam int VIC_NSER  = 4;
    localparam int VIC_SLOT_W = $clog2(VIC_NSER);
    localparam int VIC_UNNAMED_KEY = 2 * VIC_NSRC;

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_MASK = 2'd1,
        A_ISR  = 2'd2,
        A_VEC  = 2'd3
    } vic_addr_e;

    // config layout: [16] enable, [15:13] level, [12:8] top source, [7:0] slots
    typedef struct packed {
        logic                                  en;
        logic [2:0]                            lvl;
        logic [VIC_VEC_W-1:0]                  top;
        logic [VIC_NSER-1:0][VIC_SLOT_W-1:0]   slot;
    } cfg_t;

    // smaller key means more urgent
    function automatic logic [VIC_KEY_W-1:0] rank_key(input int v, input cfg_t c, input int ser_base);
        int found;
        found = -1;
        if (v == int'(c.top)) return '0;
        if (v >= ser_base && v < ser_base + VIC_NSER) begin
            for (int s = VIC_NSER - 1; s >= 0; s--) begin
                if (int'(c.slot[s]) == v - ser_base) found = s;
            end
            if (found < 0) return VIC_KEY_W'(VIC_UNNAMED_KEY);
            return VIC_KEY_W'(ser_base + found + 1);
        end
        return VIC_KEY_W'(v + 1);
    endfunction

endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
    parameter int NSRC = vic_pkg::VIC_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);

    localparam logic [NSRC-1:0] ERR_BIT = NSRC'(1);

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } pst_t;

    pst_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = (s_q.pend & ~clr_i) | (set_i & ~ERR_BIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;

    assert_src0_never_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pend[0]);

    assert_set_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~ERR_BIT)) |=> (|s_q.pend));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NSRC     = vic_pkg::VIC_NSRC,
    parameter int VEC_W    = vic_pkg::VIC_VEC_W,
    parameter int KEY_W    = vic_pkg::VIC_KEY_W,
    parameter int SER_BASE = 27
) (
    input  logic            [NSRC-1:0]  cand_i,
    input  vic_pkg::cfg_t               cfg_i,
    output logic                        any_o,
    output logic            [VEC_W-1:0] vec_o,
    output logic            [KEY_W-1:0] key_o
);

    logic [NSRC-1:0][KEY_W-1:0] keys;

    for (genvar g = 0; g < NSRC; g++) begin : g_key
        assign keys[g] = vic_pkg::rank_key(g, cfg_i, SER_BASE);
    end

    always_comb begin
        any_o = 1'b0;
        vec_o = '0;
        key_o = '1;
        for (int v = 0; v < NSRC; v++) begin
            if (cand_i[v] && (!any_o || keys[v] < key_o)) begin
                any_o = 1'b1;
                vec_o = VEC_W'(v);
                key_o = keys[v];
            end
        end
    end

    always_comb begin
        if (any_o) begin
            assert_win_is_candidate_R5: assert (cand_i[vec_o]);
        end
    end

endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int NSRC     = vic_pkg::VIC_NSRC,
    parameter int SER_BASE = 27
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] src_in,
    output logic        irq_req,
    output logic [2:0]  irq_level
);
    import vic_pkg::*;

    localparam int VEC_W   = $clog2(NSRC);
    localparam int KEY_W   = VEC_W + 2;
    localparam int VEC_LSB = 16 - VEC_W;
    localparam int CFG_W   = $bits(cfg_t);

    typedef struct packed {
        cfg_t             cfg;
        logic [NSRC-1:0]  mask;
        logic [NSRC-1:0]  isr;
        logic [VEC_W-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0]  pend, cand, pend_clr;
    logic             c_any, i_any, ack;
    logic [VEC_W-1:0] c_vec, i_vec;
    logic [KEY_W-1:0] c_key, i_key;

    assign cand = pend & st_q.mask;

    vic_pending #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_in[NSRC-1:0]),
        .clr_i  (pend_clr),
        .pend_o (pend)
    );

    vic_prio #(.NSRC(NSRC), .VEC_W(VEC_W), .KEY_W(KEY_W), .SER_BASE(SER_BASE)) u_cand_sel (
        .cand_i (cand),
        .cfg_i  (st_q.cfg),
        .any_o  (c_any),
        .vec_o  (c_vec),
        .key_o  (c_key)
    );

    vic_prio #(.NSRC(NSRC), .VEC_W(VEC_W), .KEY_W(KEY_W), .SER_BASE(SER_BASE)) u_isr_sel (
        .cand_i (st_q.isr),
        .cfg_i  (st_q.cfg),
        .any_o  (i_any),
        .vec_o  (i_vec),
        .key_o  (i_key)
    );

    assign ack = reg_wr && (vic_addr_e'(reg_addr) == A_VEC) && reg_wdata[0];

    always_comb begin
        st_d     = st_q;
        pend_clr = '0;
        if (reg_wr) begin
            case (vic_addr_e'(reg_addr))
                A_CFG:  st_d.cfg  = cfg_t'(reg_wdata[CFG_W-1:0]);
                A_MASK: st_d.mask = reg_wdata[NSRC-1:0];
                A_ISR:  st_d.isr  = st_q.isr & ~reg_wdata[NSRC-1:0];
                default: ;
            endcase
        end
        if (ack) begin
            if (c_any) begin
                st_d.vec        = c_vec;
                st_d.isr[c_vec] = 1'b1;
                pend_clr[c_vec] = 1'b1;
            end else begin
                st_d.vec = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (vic_addr_e'(reg_addr))
            A_CFG:   reg_rdata = 32'(st_q.cfg);
            A_MASK:  reg_rdata = 32'(st_q.mask);
            A_ISR:   reg_rdata = 32'(st_q.isr);
            default: reg_rdata = 32'({st_q.vec, {VEC_LSB{1'b0}}});
        endcase
    end

    assign irq_req   = st_q.cfg.en && c_any && (!i_any || c_key < i_key);
    assign irq_level = st_q.cfg.lvl;

    assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && c_any) |=> st_q.isr[$past(c_vec)]);

    assert_err_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !c_any) |=> (st_q.vec == '0 && $stable(st_q.isr)));

    assert_isr_write_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && vic_addr_e'(reg_addr) == A_ISR) |=> ((st_q.isr & ~$past(st_q.isr)) == '0));

    assert_isr_winner_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        i_any |-> st_q.isr[i_vec]);

    assert_irq_needs_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (st_q.cfg.en && (|(pend & st_q.mask))));

endmodule

// File: tb/sim_vic_top.sv
`timescale 1ns/1ps
module sim_vic_top;

    localparam int SB = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] src_in = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;

    vic_top #(.NSRC(32), .SER_BASE(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
        .irq_req(irq_req), .irq_level(irq_level)
    );

    always #4 clk = ~clk;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    logic [16:0] m_cfg;
    logic [31:0] m_mask, m_isr, m_pend;
    logic [4:0]  m_vec;

    function automatic int mkey(input int v, input logic [16:0] c);
        if (v == int'(c[12:8])) return 0;
        if (v >= SB && v < SB + 4) begin
            for (int s = 0; s < 4; s++)
                if (int'(c[2*s +: 2]) == v - SB) return SB + s + 1;
            return 64;
        end
        return v + 1;
    endfunction

    function automatic void mbest(input logic [31:0] cand, input logic [16:0] c,
                                  output bit any, output int vec, output int key);
        any = 0; vec = 0; key = 1000;
        for (int v = 0; v < 32; v++) begin
            if (cand[v] && mkey(v, c) < key) begin
                any = 1; vec = v; key = mkey(v, c);
            end
        end
    endfunction

    function automatic bit exp_irq();
        bit ca, ia; int cv, ck, iv, ik;
        mbest(m_pend & m_mask, m_cfg, ca, cv, ck);
        mbest(m_isr, m_cfg, ia, iv, ik);
        return m_cfg[16] && ca && (!ia || ck < ik);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input logic [1:0] a, input logic [31:0] d, input logic [31:0] s);
        bit any; int bv, bk;
        logic [31:0] np, ni, nm; logic [16:0] nc; logic [4:0] nv;
        np = m_pend; ni = m_isr; nm = m_mask; nc = m_cfg; nv = m_vec;
        mbest(m_pend & m_mask, m_cfg, any, bv, bk);
        if (wr) begin
            case (a)
                2'd0: nc = d[16:0];
                2'd1: nm = d;
                2'd2: ni = m_isr & ~d;
                default: if (d[0]) begin
                    if (any) begin nv = 5'(bv); ni[bv] = 1'b1; np[bv] = 1'b0; end
                    else nv = 5'd0;
                end
            endcase
        end
        np = np | (s & 32'hFFFF_FFFE);
        reg_wr = wr; reg_addr = a; reg_wdata = d; src_in = s;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; src_in = '0;
        m_pend = np; m_isr = ni; m_mask = nm; m_cfg = nc; m_vec = nv;
        chk("R4 irq_req", 32'(irq_req), 32'(exp_irq()));
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] q);
        reg_addr = a;
        #1;
        q = reg_rdata;
    endtask

    task automatic ack_exp(input string tag, input int e);
        logic [31:0] q;
        cyc(1'b1, 2'd3, 32'd1, '0);
        rd(2'd3, q);
        chk(tag, q, 32'(e) << 11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        void'($urandom(32'd20240611));
        m_cfg = '0; m_mask = '0; m_isr = '0; m_pend = '0; m_vec = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), q);
            chk("R1 reset register", q, 32'd0);
        end
        chk("R1 reset irq", 32'(irq_req), 32'd0);

        // R2: source 0 ignored
        cyc(1'b1, 2'd0, 32'h0001_0000, '0);
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
        cyc(1'b0, 2'd0, 0, 32'h1);
        chk("R2 src0 no request", 32'(irq_req), 32'd0);
        ack_exp("R8 ack with nothing pending", 0);

        // R3 and R8: masked source
        cyc(1'b1, 2'd1, 32'd0, '0);
        cyc(1'b0, 2'd0, 0, 32'd1 << 5);
        chk("R3 masked no request", 32'(irq_req), 32'd0);
        ack_exp("R8 masked before ack", 0);
        rd(2'd2, q); chk("R8 isr unchanged", q, 32'd0);
        cyc(1'b1, 2'd1, 32'd1 << 5, '0);
        chk("R3 unmask restores request", 32'(irq_req), 32'd1);
        ack_exp("R7 R9 vector 5", 5);
        rd(2'd2, q); chk("R7 isr set", q, 32'd1 << 5);
        chk("R4 in service blocks", 32'(irq_req), 32'd0);

        // R10: write-one-to-clear
        cyc(1'b1, 2'd2, 32'd0, '0);
        rd(2'd2, q); chk("R10 zero write no effect", q, 32'd1 << 5);
        cyc(1'b1, 2'd2, 32'd1 << 5, '0);
        rd(2'd2, q); chk("R10 clear", q, 32'd0);

        // R5: top source field
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
        cyc(1'b1, 2'd0, 32'h0001_0900, '0);
        cyc(1'b0, 2'd0, 0, (32'd1 << 3) | (32'd1 << 9) | (32'd1 << 20));
        ack_exp("R5 top source first", 9);
        chk("R4 lower rank than in-service", 32'(irq_req), 32'd0);
        ack_exp("R5 ascending next", 3);
        ack_exp("R5 ascending last", 20);
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, '0);

        // R7: acknowledge bit clear
        cyc(1'b0, 2'd0, 0, 32'd1 << 12);
        cyc(1'b1, 2'd3, 32'd0, '0);
        rd(2'd3, q); chk("R7 no-ack write keeps vector", q, 32'd20 << 11);
        rd(2'd2, q); chk("R7 no-ack write keeps isr", q, 32'd0);
        ack_exp("R7 pending kept", 12);
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, '0);

        // R6: serial slot remap, permutation
        cyc(1'b1, 2'd0, 32'h0001_001B, '0);
        cyc(1'b0, 2'd0, 0, (32'd1 << 27) | (32'd1 << 30));
        ack_exp("R6 remapped slot0", 30);
        ack_exp("R6 remapped slot3", 27);
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, '0);
        // R6: duplicated slot fields
        cyc(1'b1, 2'd0, 32'h0001_0055, '0);
        cyc(1'b0, 2'd0, 0, (32'd1 << 10) | (32'd1 << 27) | (32'd1 << 28) | (32'd1 << 30));
        ack_exp("R6 plain below serial", 10);
        ack_exp("R6 named channel", 28);
        ack_exp("R6 unnamed lowest", 27);
        ack_exp("R6 unnamed tie by number", 30);
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, '0);

        // R4: global enable
        cyc(1'b1, 2'd0, 32'h0000_001B, '0);
        cyc(1'b0, 2'd0, 0, 32'd1 << 4);
        chk("R4 enable off", 32'(irq_req), 32'd0);
        cyc(1'b1, 2'd0, 32'h0001_001B, '0);
        chk("R4 enable on", 32'(irq_req), 32'd1);
        ack_exp("R4 served", 4);
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, '0);

        // R11: level field and readback
        cyc(1'b1, 2'd0, 32'h0001_A01B, '0);
        chk("R11 irq_level", 32'(irq_level), 32'd5);
        rd(2'd0, q); chk("R11 config read", q, 32'h0001_A01B);
        cyc(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
        rd(2'd0, q); chk("R11 config upper bits", q, 32'h0001_FFFF);
        chk("R11 irq_level max", 32'(irq_level), 32'd7);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [31:0] d;
            sel = int'($urandom % 100);
            if (sel < 40) begin
                cyc(1'b0, 2'd0, 0, $urandom & $urandom & $urandom);
            end else if (sel < 52) begin
                cyc(1'b1, 2'd1, $urandom | $urandom, '0);
            end else if (sel < 60) begin
                d = $urandom;
                d[16] = ($urandom % 8) != 0;
                cyc(1'b1, 2'd0, d, '0);
                rd(2'd0, q); chk("R11 random config", q, {15'd0, m_cfg});
            end else if (sel < 78) begin
                cyc(1'b1, 2'd3, 32'd1, '0);
                rd(2'd3, q); chk("R7 R9 random ack", q, 32'(m_vec) << 11);
            end else if (sel < 90) begin
                cyc(1'b1, 2'd2, $urandom & $urandom, '0);
                rd(2'd2, q); chk("R10 random isr", q, m_isr);
            end else begin
                rd(2'd1, q); chk("R3 mask read", q, m_mask);
                rd(2'd2, q); chk("R10 isr read", q, m_isr);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule